// File: doc/BRIEF.md
# PCI host bridge configuration space

This block holds the 256-byte configuration space of a single-function PCI host bridge. An upstream decoder delivers byte accesses that are already resolved to an offset. Each access has an offset, write data, a write strobe and a read strobe. At reset the space holds the bridge's identification, class and default command and status values. Software can change only the command and status bytes and the device-specific area from offset 0x40 upward. Writes to any other offset are discarded without effect.

Two companion blocks take their settings straight from the stored bytes:

- A shadow-region decoder takes its enables from offset 0x44 and its access mode from offset 0x45.
- An interrupt router takes one routing byte for each of four PCI interrupt lines from offsets 0xC0 to 0xC3.

A separate PCI master-reset pulse turns off the upper four shadow enables and leaves everything else alone. A one-cycle pulse tells the shadow decoder when its settings have actually changed.

Top module: `pci_host_cfg_space`

## Requirements
- R1: After reset, offsets 0x00, 0x01, 0x02 and 0x03 read 0x39, 0x10, 0x96 and 0x04, so the vendor word is 0x1039 and the device word is 0x0496.
- R2: After reset, the default bytes are as follows, and every offset not listed here reads 0x00:

  | Offset | Value | Contents |
  |--------|-------|----------|
  | 0x04 | 0x07 | command, low byte |
  | 0x05 | 0x00 | command, high byte |
  | 0x06 | 0x80 | status, low byte |
  | 0x07 | 0x02 | status, high byte |
  | 0x08 | 0x02 | revision |
  | 0x09 | 0x00 | class code |
  | 0x0A | 0x00 | class code |
  | 0x0B | 0x06 | class code (host bridge) |
  | 0x0E | 0x00 | header type (single function) |

  The registered read data is also 0x00 after reset.
- R3: A write strobe to an offset from 0x04 to 0x07 stores the write data at that offset.
- R4: A write strobe to any offset of 0x40 or above stores the write data at that offset.
- R5: A write strobe to an offset from 0x00 to 0x03 or from 0x08 to 0x3F leaves the stored byte unchanged.
- R6: A read strobe captures the byte at the offset, and the read data appears on the clock edge that samples the strobe. When there is no read strobe, the read data holds its value. A read in the same cycle as a write to the same offset returns the old byte.
- R7: A master-reset pulse replaces offset 0x44 with its current value ANDed with 0x0F, and leaves every other byte unchanged.
- R8: When a master-reset pulse and a write to 0x44 fall in the same cycle, the write is dropped and the masked value is stored. A write to any other offset in that cycle is stored as normal.
- R9: The mapping-changed output is high for exactly the cycle after an edge that changed the content of 0x44 or 0x45. It stays low when a write or a master reset leaves both bytes as they were.
- R10: The shadow-enable output mirrors 0x44 and the shadow-mode output mirrors 0x45. The routing output carries 0xC0 in bits 7:0, 0xC1 in bits 15:8, 0xC2 in bits 23:16 and 0xC3 in bits 31:24.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 8 | Byte offset of the access |
| wdata_i | input | 8 | Write data |
| we_i | input | 1 | Write strobe |
| re_i | input | 1 | Read strobe |
| mst_rst_i | input | 1 | PCI master-reset pulse |
| rdata_o | output | 8 | Registered read data |
| shadow_en_o | output | 8 | Contents of offset 0x44 |
| shadow_mode_o | output | 8 | Contents of offset 0x45 |
| irq_route_o | output | 32 | Contents of offsets 0xC0 to 0xC3 |
| map_chg_o | output | 1 | One-cycle pulse after 0x44 or 0x45 changes |

## Verification
The hardest case to reach is the collision of a master-reset pulse with a write in the same cycle, either to 0x44 or to an unrelated offset, along with the related case of a read and a write to the same offset in one cycle. The stimulus drives every port through a single one-cycle task, so these collisions are built on purpose rather than by chance. The stimulus also covers the cases where the pulse must not fire: a rewrite of 0x44 with its current value, and a master reset once the upper nibble is already clear.

// File: rtl/pci_cfg_pkg.sv
package pci_cfg_pkg;
  localparam int CFG_AW = 8;
  localparam int CFG_DW = 8;
  localparam int CFG_NUM_INT = 4;

  localparam logic [7:0] OFS_SHADOW_EN   = 8'h44;
  localparam logic [7:0] OFS_SHADOW_MODE = 8'h45;
  localparam logic [7:0] OFS_IRQ_BASE    = 8'hC0;
  localparam logic [7:0] SHADOW_KEEP     = 8'h0F;

  function automatic logic [7:0] cfg_reset_val(input int unsigned ofs);
    case (ofs)
      0:       return 8'h39;
      1:       return 8'h10;
      2:       return 8'h96;
      3:       return 8'h04;
      4:       return 8'h07;
      6:       return 8'h80;
      7:       return 8'h02;
      8:       return 8'h02;
      11:      return 8'h06;
      default: return 8'h00;
    endcase
  endfunction

  function automatic bit cfg_writable(input int unsigned ofs);
    return (ofs >= 4 && ofs <= 7) || ofs >= 64;
  endfunction
endpackage

// File: rtl/pci_cfg_wr_ctrl.sv
module pci_cfg_wr_ctrl
  import pci_cfg_pkg::*;
#(
  parameter int AW = CFG_AW,
  parameter int DW = CFG_DW
) (
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          we_i,
  input  logic          mst_rst_i,
  input  logic [DW-1:0] cur_en_i,
  input  logic [DW-1:0] cur_mode_i,
  output logic          wr_en_o,
  output logic [AW-1:0] wr_addr_o,
  output logic [DW-1:0] wr_data_o,
  output logic          clr_en_o,
  output logic [DW-1:0] clr_data_o,
  output logic          map_chg_d_o
);
  logic          allowed;
  logic          hit_en;
  logic          hit_mode;
  logic [DW-1:0] en_next;
  logic [DW-1:0] mode_next;

  always_comb begin
    allowed  = cfg_writable(int'(addr_i));
    hit_en   = addr_i == AW'(OFS_SHADOW_EN);
    hit_mode = addr_i == AW'(OFS_SHADOW_MODE);
    // master reset owns 0x44 in a collision
    wr_en_o    = we_i && allowed && !(mst_rst_i && hit_en);
    wr_addr_o  = addr_i;
    wr_data_o  = wdata_i;
    clr_en_o   = mst_rst_i;
    clr_data_o = cur_en_i & DW'(SHADOW_KEEP);

    if (mst_rst_i)              en_next = clr_data_o;
    else if (wr_en_o && hit_en) en_next = wdata_i;
    else                        en_next = cur_en_i;

    mode_next   = (wr_en_o && hit_mode) ? wdata_i : cur_mode_i;
    map_chg_d_o = (en_next != cur_en_i) || (mode_next != cur_mode_i);
  end
endmodule

// File: rtl/pci_cfg_regfile.sv
module pci_cfg_regfile
  import pci_cfg_pkg::*;
#(
  parameter  int AW    = CFG_AW,
  parameter  int DW    = CFG_DW,
  localparam int DEPTH = 1 << AW
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      wr_en_i,
  input  logic [AW-1:0]             wr_addr_i,
  input  logic [DW-1:0]             wr_data_i,
  input  logic                      clr_en_i,
  input  logic [DW-1:0]             clr_data_i,
  output logic [DEPTH-1:0][DW-1:0]  q_o
);
  for (genvar i = 0; i < DEPTH; i++) begin : g_byte
    if (cfg_writable(i)) begin : g_rw
      localparam bit IS_SHD = (i == int'(OFS_SHADOW_EN));
      logic [DW-1:0] r;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                                r <= DW'(cfg_reset_val(i));
        else if (IS_SHD && clr_en_i)                r <= clr_data_i;
        else if (wr_en_i && wr_addr_i == AW'(i))    r <= wr_data_i;
      end
      assign q_o[i] = r;
    end else begin : g_ro
      // read-only bytes never change: no storage
      assign q_o[i] = DW'(cfg_reset_val(i));
    end
  end
endmodule

// File: rtl/pci_cfg_rd_port.sv
module pci_cfg_rd_port
  import pci_cfg_pkg::*;
#(
  parameter  int AW    = CFG_AW,
  parameter  int DW    = CFG_DW,
  localparam int DEPTH = 1 << AW
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     re_i,
  input  logic [AW-1:0]            addr_i,
  input  logic [DEPTH-1:0][DW-1:0] q_i,
  output logic [DW-1:0]            rdata_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_o <= '0;
    else if (re_i) rdata_o <= q_i[addr_i];
  end
endmodule

// File: rtl/pci_host_cfg_space.sv
module pci_host_cfg_space
  import pci_cfg_pkg::*;
#(
  parameter int AW      = CFG_AW,
  parameter int DW      = CFG_DW,
  parameter int NUM_INT = CFG_NUM_INT
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [AW-1:0]         addr_i,
  input  logic [DW-1:0]         wdata_i,
  input  logic                  we_i,
  input  logic                  re_i,
  input  logic                  mst_rst_i,
  output logic [DW-1:0]         rdata_o,
  output logic [DW-1:0]         shadow_en_o,
  output logic [DW-1:0]         shadow_mode_o,
  output logic [NUM_INT*DW-1:0] irq_route_o,
  output logic                  map_chg_o
);
  localparam int DEPTH = 1 << AW;

  logic [DEPTH-1:0][DW-1:0] q;
  logic          wr_en;
  logic [AW-1:0] wr_addr;
  logic [DW-1:0] wr_data;
  logic          clr_en;
  logic [DW-1:0] clr_data;
  logic          map_chg_d;
  logic          map_chg_q;

  pci_cfg_wr_ctrl #(.AW(AW), .DW(DW)) i_wr_ctrl (
    .addr_i      (addr_i),
    .wdata_i     (wdata_i),
    .we_i        (we_i),
    .mst_rst_i   (mst_rst_i),
    .cur_en_i    (q[OFS_SHADOW_EN]),
    .cur_mode_i  (q[OFS_SHADOW_MODE]),
    .wr_en_o     (wr_en),
    .wr_addr_o   (wr_addr),
    .wr_data_o   (wr_data),
    .clr_en_o    (clr_en),
    .clr_data_o  (clr_data),
    .map_chg_d_o (map_chg_d)
  );

  pci_cfg_regfile #(.AW(AW), .DW(DW)) i_regfile (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en),
    .wr_addr_i  (wr_addr),
    .wr_data_i  (wr_data),
    .clr_en_i   (clr_en),
    .clr_data_i (clr_data),
    .q_o        (q)
  );

  pci_cfg_rd_port #(.AW(AW), .DW(DW)) i_rd_port (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .re_i    (re_i),
    .addr_i  (addr_i),
    .q_i     (q),
    .rdata_o (rdata_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) map_chg_q <= 1'b0;
    else         map_chg_q <= map_chg_d;
  end

  assign map_chg_o     = map_chg_q;
  assign shadow_en_o   = q[OFS_SHADOW_EN];
  assign shadow_mode_o = q[OFS_SHADOW_MODE];

  for (genvar k = 0; k < NUM_INT; k++) begin : g_irq
    assign irq_route_o[k*DW +: DW] = q[int'(OFS_IRQ_BASE) + k];
  end
endmodule

// File: rtl/pci_host_cfg_space_chk.sv
module pci_host_cfg_space_chk
  import pci_cfg_pkg::*;
#(
  parameter int AW      = CFG_AW,
  parameter int DW      = CFG_DW,
  parameter int NUM_INT = CFG_NUM_INT
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic [AW-1:0]         addr_i,
  input logic [DW-1:0]         wdata_i,
  input logic                  we_i,
  input logic                  re_i,
  input logic                  mst_rst_i,
  input logic [DW-1:0]         rdata_o,
  input logic [DW-1:0]         shadow_en_o,
  input logic [DW-1:0]         shadow_mode_o,
  input logic [NUM_INT*DW-1:0] irq_route_o,
  input logic                  map_chg_o
);
  assert_irq_write_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == AW'(OFS_IRQ_BASE) && !mst_rst_i) |=> irq_route_o[DW-1:0] == $past(wdata_i));

  assert_rdata_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !re_i |=> $stable(rdata_o));

  assert_mst_clear_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mst_rst_i |=> shadow_en_o == ($past(shadow_en_o) & DW'(SHADOW_KEEP)));

  assert_map_on_change_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (shadow_en_o != $past(shadow_en_o) || shadow_mode_o != $past(shadow_mode_o)) |-> map_chg_o);

  assert_map_only_change_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    map_chg_o |-> (shadow_en_o != $past(shadow_en_o) || shadow_mode_o != $past(shadow_mode_o)));
endmodule

bind pci_host_cfg_space pci_host_cfg_space_chk #(.AW(AW), .DW(DW), .NUM_INT(NUM_INT)) i_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .addr_i        (addr_i),
  .wdata_i       (wdata_i),
  .we_i          (we_i),
  .re_i          (re_i),
  .mst_rst_i     (mst_rst_i),
  .rdata_o       (rdata_o),
  .shadow_en_o   (shadow_en_o),
  .shadow_mode_o (shadow_mode_o),
  .irq_route_o   (irq_route_o),
  .map_chg_o     (map_chg_o)
);

// File: tb/test_pci_host_cfg_space.sv
`timescale 1ns/1ps
module test_pci_host_cfg_space;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [7:0]  addr_i = '0;
  logic [7:0]  wdata_i = '0;
  logic        we_i = 1'b0;
  logic        re_i = 1'b0;
  logic        mst_rst_i = 1'b0;
  logic [7:0]  rdata_o;
  logic [7:0]  shadow_en_o;
  logic [7:0]  shadow_mode_o;
  logic [31:0] irq_route_o;
  logic        map_chg_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  pci_host_cfg_space i_pci_host_cfg_space (
    .clk_i(clk), .rst_ni(rst_ni), .addr_i(addr_i), .wdata_i(wdata_i),
    .we_i(we_i), .re_i(re_i), .mst_rst_i(mst_rst_i), .rdata_o(rdata_o),
    .shadow_en_o(shadow_en_o), .shadow_mode_o(shadow_mode_o),
    .irq_route_o(irq_route_o), .map_chg_o(map_chg_o)
  );

  // {offset, write data, expected readback}
  localparam int NV = 12;
  localparam logic [23:0] VEC [NV] = '{
    {8'h04, 8'hAA, 8'hAA}, {8'h07, 8'h5C, 8'h5C}, {8'h00, 8'hFF, 8'h39},
    {8'h03, 8'h11, 8'h04}, {8'h08, 8'h33, 8'h02}, {8'h3F, 8'h77, 8'h00},
    {8'h40, 8'h12, 8'h12}, {8'hFF, 8'hE1, 8'hE1}, {8'h0B, 8'h01, 8'h06},
    {8'hC1, 8'h85, 8'h85}, {8'h10, 8'hAB, 8'h00}, {8'h80, 8'h3C, 8'h3C}
  };
  localparam int VTAG [NV] = '{3, 3, 5, 5, 5, 5, 4, 4, 5, 4, 5, 4};

  function automatic string tag_name(input int t);
    case (t)
      3:       return "R3";
      4:       return "R4";
      default: return "R5";
    endcase
  endfunction

  function automatic logic [7:0] exp_reset(input int ofs);
    case (ofs)
      0: return 8'h39; 1: return 8'h10; 2: return 8'h96; 3: return 8'h04;
      4: return 8'h07; 6: return 8'h80; 7: return 8'h02; 8: return 8'h02;
      11: return 8'h06;
      default: return 8'h00;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // one clock: drive at negedge, return at the next negedge
  task automatic cyc(input logic [7:0] a, input logic [7:0] d,
                     input logic w, input logic r, input logic m);
    addr_i = a; wdata_i = d; we_i = w; re_i = r; mst_rst_i = m;
    @(negedge clk);
    we_i = 1'b0; re_i = 1'b0; mst_rst_i = 1'b0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    cyc(a, d, 1'b1, 1'b0, 1'b0);
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] v);
    cyc(a, 8'h00, 1'b0, 1'b1, 1'b0);
    v = rdata_o;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);

    // R2 reset state of outputs
    chk("R2 rdata", {24'h0, rdata_o}, 32'h0);
    chk("R2 map", {31'h0, map_chg_o}, 32'h0);
    chk("R2 irq", irq_route_o, 32'h0);
    chk("R2 shadow", {24'h0, shadow_en_o}, 32'h0);

    // R1 R2 full reset image
    for (int i = 0; i < 256; i++) begin
      rd(8'(i), v);
      chk(i < 4 ? "R1 id" : "R2 default", {24'h0, v}, {24'h0, exp_reset(i)});
    end

    // write/readback table (R3 R4 R5)
    for (int i = 0; i < NV; i++) begin
      wr(VEC[i][23:16], VEC[i][15:8]);
      rd(VEC[i][23:16], v);
      chk(tag_name(VTAG[i]), {24'h0, v}, {24'h0, VEC[i][7:0]});
    end

    // R10 routing and shadow mirrors
    wr(8'hC0, 8'h8A);
    wr(8'hC3, 8'h0F);
    chk("R10 irq", irq_route_o, 32'h0F00858A);

    // R9 change pulse
    wr(8'h44, 8'hF5);
    chk("R9 pulse en", {31'h0, map_chg_o}, 32'h1);
    chk("R10 shadow_en", {24'h0, shadow_en_o}, 32'hF5);
    @(negedge clk);
    chk("R9 pulse ends", {31'h0, map_chg_o}, 32'h0);
    wr(8'h45, 8'h03);
    chk("R9 pulse mode", {31'h0, map_chg_o}, 32'h1);
    chk("R10 shadow_mode", {24'h0, shadow_mode_o}, 32'h03);
    wr(8'h44, 8'hF5);
    chk("R9 same value", {31'h0, map_chg_o}, 32'h0);
    wr(8'h46, 8'h11);
    chk("R9 other ofs", {31'h0, map_chg_o}, 32'h0);

    // R7 master reset
    cyc(8'h00, 8'h00, 1'b0, 1'b0, 1'b1);
    chk("R7 clear", {24'h0, shadow_en_o}, 32'h05);
    chk("R9 mst pulse", {31'h0, map_chg_o}, 32'h1);
    rd(8'h45, v);
    chk("R7 mode kept", {24'h0, v}, 32'h03);
    rd(8'h46, v);
    chk("R7 other kept", {24'h0, v}, 32'h11);
    cyc(8'h00, 8'h00, 1'b0, 1'b0, 1'b1);
    chk("R7 idempotent", {24'h0, shadow_en_o}, 32'h05);
    chk("R9 no change", {31'h0, map_chg_o}, 32'h0);

    // R8 collisions
    wr(8'h44, 8'hFA);
    cyc(8'h44, 8'hA0, 1'b1, 1'b0, 1'b1);
    chk("R8 mst wins", {24'h0, shadow_en_o}, 32'h0A);
    chk("R9 collide pulse", {31'h0, map_chg_o}, 32'h1);
    cyc(8'h60, 8'h5A, 1'b1, 1'b0, 1'b1);
    chk("R8 en kept", {24'h0, shadow_en_o}, 32'h0A);
    rd(8'h60, v);
    chk("R8 other write", {24'h0, v}, 32'h5A);

    // R6 read timing
    repeat (3) @(negedge clk);
    chk("R6 hold", {24'h0, rdata_o}, 32'h5A);
    cyc(8'h60, 8'h77, 1'b1, 1'b1, 1'b0);
    chk("R6 rdw old", {24'h0, rdata_o}, 32'h5A);
    rd(8'h60, v);
    chk("R6 new", {24'h0, v}, 32'h77);
    rd(8'h00, v);
    chk("R6 id read", {24'h0, v}, 32'h39);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule